// File: doc/BRIEF.md
# Filtered fan duty ramp controller

This block sits between an automatic fan control law and the fan's PWM generator. It receives a target duty and drives a current duty. With filtering on, the current duty moves toward the target one bounded step at a time rather than jumping, which smooths audible fan-speed changes. Duty is an 8-bit count from 0 to 240, where 240 means full duty, so one unit is 1/240 of full scale.

Steps are taken only on a temperature-update tick. The tick comes from an internal divider whose period doubles for each code step below the fastest setting. One 8-bit control register sets four things: whether filtering is on, the step size, the tick rate, and whether spin-up is suppressed. When spin-up is allowed and the fan starts from rest, the output is held at full duty for a fixed number of ticks, and ramping then begins from zero.

Parameter `PRESCALE` is the tick period at the fastest rate code, counted in `clk` cycles. It defaults to 6,250,000, which gives eight updates per second from a 50 MHz clock. Parameter `SPIN_TICKS` is the spin-up length, counted in ticks.

Top module: `fan_duty_slew`

## Requirements
- R1: After reset, the control register reads 0x10 (rate code 100, every other field 0) and the duty output is 0.
- R2: The control register fields are: bit 0 enables filtering, bit 1 is reserved and always reads 0, bits 4:2 are the rate code, bits 6:5 are the step code, and bit 7 set to 1 suppresses spin-up. Every other bit reads back exactly as written.
- R3: With rate code c (0 to 7), `upd_tick` is high for one cycle in every PRESCALE·2^(7−c) cycles. Code 111 is the fastest rate and code 000 is 128 times slower.
- R4: Any register write restarts the divider. The first tick after a write comes PRESCALE·2^(7−c) cycles after the write cycle, and no tick occurs in the cycle that follows a write.
- R5: With filtering off, the duty equals the clamped target one cycle after that target is presented.
- R6: With filtering on, the duty output changes only in the cycle after an `upd_tick` cycle.
- R7: With filtering on, each tick moves the duty toward the target by 1, 2, 4 or 8 units for step codes 00, 01, 10 and 11.
- R8: A step that would pass the target lands exactly on the target, in both directions.
- R9: A target above 240 is treated as 240, and the duty output never exceeds 240.
- R10: With filtering on and spin-up allowed, a tick that finds the duty at 0 and a nonzero target forces the output to 240. The output stays at 240 until the SPIN_TICKS-th tick after that one, which sets the duty to min(step, target).
- R11: With bit 7 set, a tick from duty 0 ramps the duty directly by one step, with no forced full duty.
- R12: If the target is 0 at a tick during spin-up, the spin-up ends and the output returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Register write strobe, one cycle per write |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Current register contents |
| target_duty | input | 8 | Target duty from the control law, 0 to 240 |
| duty | output | 8 | Current duty toward the PWM generator |
| upd_tick | output | 1 | One-cycle temperature-update tick |

## Verification
The assertions assume that `PRESCALE` is at least 2, so that a write and the next tick never fall in the same cycle. They also assume that `target_duty` and the register change only through the ports, once per clock. The stimulus drives every input half a cycle away from the active edge and issues each write as a single-cycle strobe. It also presents targets above 240 on purpose, to exercise the clamp. Spin-up is entered only from a settled zero duty, and the aborting target is applied between ticks, which matches what the spin-up properties expect.

// File: rtl/fds_pkg.sv
package fds_pkg;
  localparam int          DUTY_W    = 8;
  localparam logic [7:0]  DUTY_FULL = 8'd240;
  localparam logic [7:0]  RSVD_MASK = 8'h02;

  typedef struct packed {
    logic       spin_dis;
    logic [1:0] ramp;
    logic [2:0] rate;
    logic       rsvd;
    logic       filt_en;
  } fds_cfg_t;

  localparam fds_cfg_t CFG_RESET = '{spin_dis: 1'b0, ramp: 2'b00, rate: 3'b100,
                                     rsvd: 1'b0, filt_en: 1'b0};

  typedef enum logic [1:0] {DIR_HOLD, DIR_UP, DIR_DOWN} fds_dir_e;

  function automatic logic [7:0] clamp_duty(input logic [7:0] v);
    return (v > DUTY_FULL) ? DUTY_FULL : v;
  endfunction
endpackage

// File: rtl/fds_cfg_reg.sv
module fds_cfg_reg
  import fds_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  logic [7:0] wdata,
  output fds_cfg_t cfg,
  output logic     restart
);
  fds_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = fds_cfg_t'(wdata & ~RSVD_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  assign cfg     = cfg_q;
  assign restart = we;
endmodule

// File: rtl/fds_tick_div.sv
module fds_tick_div #(
  parameter int PRESCALE = 6250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [2:0] rate,
  output logic       tick
);
  localparam int SPAN_MAX = PRESCALE * 128;
  localparam int CNT_W    = $clog2(SPAN_MAX);

  logic [CNT_W-1:0] lim_tab [8];
  logic [CNT_W-1:0] cnt_q, cnt_d, lim;

  for (genvar g = 0; g < 8; g++) begin : g_lim
    assign lim_tab[g] = CNT_W'((SPAN_MAX >> g) - 1);
  end

  assign lim  = lim_tab[rate];
  assign tick = (cnt_q == lim);

  always_comb begin
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fds_slew.sv
module fds_slew
  import fds_pkg::*;
#(
  parameter int SPIN_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       filt_en,
  input  logic       spin_dis,
  input  logic [1:0] ramp,
  input  logic       tick,
  input  logic [7:0] target,
  output logic [7:0] duty_o,
  output logic       spin_o
);
  localparam int              SPIN_W    = $clog2(SPIN_TICKS + 1);
  localparam logic [SPIN_W-1:0] SPIN_LOAD = SPIN_W'(SPIN_TICKS);

  logic [7:0]        step_tab [4];
  logic [7:0]        duty_q, duty_d, tgt, step;
  logic [8:0]        up_sum;
  logic [SPIN_W-1:0] spin_q, spin_d;
  fds_dir_e          dir;

  for (genvar g = 0; g < 4; g++) begin : g_step
    assign step_tab[g] = 8'(1 << g);
  end

  assign tgt    = clamp_duty(target);
  assign step   = step_tab[ramp];
  assign up_sum = {1'b0, duty_q} + {1'b0, step};

  always_comb begin
    if (duty_q < tgt)      dir = DIR_UP;
    else if (duty_q > tgt) dir = DIR_DOWN;
    else                   dir = DIR_HOLD;
  end

  always_comb begin
    duty_d = duty_q;
    spin_d = spin_q;
    if (!filt_en) begin
      duty_d = tgt;
      spin_d = '0;
    end else if (tick) begin
      if (spin_q != '0) begin
        if (tgt == '0) begin
          spin_d = '0;
        end else if (spin_q == SPIN_W'(1)) begin
          spin_d = '0;
          duty_d = (step > tgt) ? tgt : step;
        end else begin
          spin_d = spin_q - SPIN_W'(1);
        end
      end else if ((duty_q == '0) && (tgt != '0) && !spin_dis) begin
        spin_d = SPIN_LOAD;
      end else begin
        case (dir)
          DIR_UP:   duty_d = (up_sum > {1'b0, tgt}) ? tgt : up_sum[7:0];
          DIR_DOWN: duty_d = ((duty_q - tgt) <= step) ? tgt : (duty_q - step);
          default:  duty_d = duty_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      spin_q <= '0;
    end else begin
      duty_q <= duty_d;
      spin_q <= spin_d;
    end
  end

  assign spin_o = (spin_q != '0);
  assign duty_o = spin_o ? DUTY_FULL : duty_q;
endmodule

// File: rtl/fan_duty_slew.sv
module fan_duty_slew
  import fds_pkg::*;
#(
  parameter int PRESCALE   = 6250000,
  parameter int SPIN_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic [7:0] target_duty,
  output logic [7:0] duty,
  output logic       upd_tick
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  fds_cfg_t   cfg;
  logic       restart;
  logic       spin_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fds_cfg_reg i_cfg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .cfg     (cfg),
    .restart (restart)
  );

  fds_tick_div #(.PRESCALE(PRESCALE)) i_div (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (restart),
    .rate    (cfg.rate),
    .tick    (upd_tick)
  );

  fds_slew #(.SPIN_TICKS(SPIN_TICKS)) i_slew (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .filt_en  (cfg.filt_en),
    .spin_dis (cfg.spin_dis),
    .ramp     (cfg.ramp),
    .tick     (upd_tick),
    .target   (target_duty),
    .duty_o   (duty),
    .spin_o   (spin_act)
  );

  assign cfg_rdata = cfg;
endmodule

// File: rtl/fds_checker.sv
module fds_checker
  import fds_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [7:0] cfg_rdata,
  input logic [7:0] target_duty,
  input logic [7:0] duty,
  input logic       upd_tick,
  input logic       spin_act
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[1] == 1'b0);

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !upd_tick);

  assert_follow_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[0] |=> duty == $past(clamp_duty(target_duty)));

  assert_hold_between_ticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[0] && !upd_tick) |=> $stable(duty));

  assert_no_overshoot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[0] && upd_tick && !spin_act && duty <= clamp_duty(target_duty))
      |=> (spin_act || duty <= $past(clamp_duty(target_duty))));

  assert_duty_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
    duty <= DUTY_FULL);

  assert_spin_ends_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (spin_act && cfg_rdata[0] && !upd_tick) |=> spin_act);

  assert_spin_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7] && !spin_act) |=> !spin_act);

  assert_spin_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (spin_act && upd_tick && clamp_duty(target_duty) == 8'd0) |=> duty == 8'd0);
endmodule

bind fan_duty_slew fds_checker i_fds_checker (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .cfg_we      (cfg_we),
  .cfg_rdata   (cfg_rdata),
  .target_duty (target_duty),
  .duty        (duty),
  .upd_tick    (upd_tick),
  .spin_act    (spin_act)
);

// File: tb/test_fan_duty_slew.sv
module test_fan_duty_slew;
  localparam int PRE  = 4;
  localparam int SPIN = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic [7:0] target_duty;
  logic [7:0] duty;
  logic       upd_tick;

  int  n_chk = 0;
  int  n_fail = 0;
  int  cyc = 0;
  bit  done = 0;
  bit  cmp_en = 0;

  // behavioural reference state
  int         m_rs = 0, m_cnt = 0, m_duty = 0, m_spin = 0;
  logic [7:0] m_reg = 8'h10;

  always #10 clk = ~clk;

  fan_duty_slew #(.PRESCALE(PRE), .SPIN_TICKS(SPIN)) i_fan_duty_slew (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .target_duty(target_duty), .duty(duty),
    .upd_tick(upd_tick)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int period(input logic [7:0] r);
    return PRE << (7 - int'(r[4:2]));
  endfunction

  always @(posedge clk) begin
    int tgt, step;
    bit tk;
    if (!rst_n) begin
      m_rs = 0; m_cnt = 0; m_duty = 0; m_spin = 0; m_reg = 8'h10;
    end else if (m_rs < 2) begin
      m_rs++;
    end else begin
      tk   = (m_cnt == period(m_reg) - 1);
      tgt  = (target_duty > 240) ? 240 : int'(target_duty);
      step = 1 << int'(m_reg[6:5]);
      if (!m_reg[0]) begin
        m_duty = tgt; m_spin = 0;
      end else if (tk) begin
        if (m_spin > 0) begin
          if (tgt == 0) m_spin = 0;
          else if (m_spin == 1) begin m_spin = 0; m_duty = (step > tgt) ? tgt : step; end
          else m_spin--;
        end else if (m_duty == 0 && tgt > 0 && !m_reg[7]) m_spin = SPIN;
        else if (m_duty < tgt) m_duty = (m_duty + step > tgt) ? tgt : m_duty + step;
        else if (m_duty > tgt) m_duty = (m_duty - step < tgt) ? tgt : m_duty - step;
      end
      if (cfg_we) begin m_cnt = 0; m_reg = cfg_wdata & 8'hFD; end
      else if (tk) m_cnt = 0;
      else m_cnt++;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R6 per-cycle duty", int'(duty), (m_spin > 0) ? 240 : m_duty);
      chk("R3 per-cycle tick", int'(upd_tick),
          int'((m_rs == 2) && (m_cnt == period(m_reg) - 1)));
      chk("R2 per-cycle register", int'(cfg_rdata), int'(m_reg));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cycles_to_tick(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!upd_tick);
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!upd_tick);
    @(negedge clk);
  endtask

  task automatic set_tgt(input int t);
    @(negedge clk); target_duty = 8'(t);
  endtask

  initial begin
    int n;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = 8'h00; target_duty = 8'd0;
    repeat (3) @(posedge clk);
    cmp_en = 1;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset register", int'(cfg_rdata), 16);
    chk("R1 reset duty", int'(duty), 0);

    cycles_to_tick(n);
    cycles_to_tick(n);
    chk("R3 default rate period", n, PRE * 8);

    cfg_write(8'hFF);
    chk("R2 reserved bit cleared", int'(cfg_rdata), 8'hFD);

    cfg_write(8'h1C);
    cycles_to_tick(n);
    chk("R4 first tick after write", n, PRE - 1);
    cycles_to_tick(n);
    chk("R3 rate 111 period", n, PRE);
    cfg_write(8'h14);
    cycles_to_tick(n);
    chk("R4 first tick after write rate 101", n, PRE * 4 - 1);
    cycles_to_tick(n);
    chk("R3 rate 101 period", n, PRE * 4);
    cfg_write(8'h00);
    cycles_to_tick(n);
    cycles_to_tick(n);
    chk("R3 rate 000 period", n, PRE * 128);

    set_tgt(100); @(negedge clk);
    chk("R5 unfiltered follow", int'(duty), 100);
    set_tgt(250); @(negedge clk);
    chk("R9 target clamp", int'(duty), 240);
    set_tgt(0); @(negedge clk);
    chk("R5 unfiltered to zero", int'(duty), 0);

    cfg_write(8'hBD);
    set_tgt(7);
    wait_tick(); chk("R11 no spin-up, step 2", int'(duty), 2);
    wait_tick(); chk("R7 step 2", int'(duty), 4);
    wait_tick(); chk("R7 step 2 again", int'(duty), 6);
    wait_tick(); chk("R8 clamp rising", int'(duty), 7);

    cfg_write(8'hFD);
    set_tgt(20);
    wait_tick(); chk("R7 step 8", int'(duty), 15);
    wait_tick(); chk("R8 clamp rising step 8", int'(duty), 20);
    set_tgt(3);
    wait_tick(); chk("R7 step 8 falling", int'(duty), 12);
    wait_tick(); chk("R7 step 8 falling again", int'(duty), 4);
    wait_tick(); chk("R8 clamp falling", int'(duty), 3);
    target_duty = 8'd100;
    repeat (2) @(negedge clk);
    chk("R6 hold between ticks", int'(duty), 3);
    wait_tick(); chk("R7 resume after hold", int'(duty), 11);

    cfg_write(8'h5D);
    set_tgt(0);
    repeat (3) wait_tick();
    chk("R7 step 4 down to zero", int'(duty), 0);
    set_tgt(10);
    wait_tick(); chk("R10 spin-up entry", int'(duty), 240);
    wait_tick(); chk("R10 spin-up held", int'(duty), 240);
    wait_tick(); chk("R10 spin-up held last", int'(duty), 240);
    wait_tick(); chk("R10 ramp after spin-up", int'(duty), 4);
    set_tgt(0);
    wait_tick(); chk("R8 down to zero", int'(duty), 0);
    set_tgt(10);
    wait_tick(); chk("R10 second entry", int'(duty), 240);
    set_tgt(0);
    wait_tick(); chk("R12 spin-up abort", int'(duty), 0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule